// File: doc/BRIEF.md
# Multi-Buffer Pixel Hit Cell

This block is the digital part of a single sensor pixel. A discriminated front-end signal (low means a charge above threshold) is captured into one of three hit memories, each opened by its own active-low strobe. Separately from the strobes, an active-low select vector picks which memory is shown to the column readout encoder. That same vector picks which memory the encoder clears after it has read the hit. Writing and reading can therefore run on different memories at once.

Each pixel also holds two configuration bits, written through a row and column addressed write port: a mask bit that hides the pixel from the readout, and a pulse-enable bit. When the pulse-enable bit is set, an external test pulse is routed in one of two ways. It can go out as an analog injection request, or it can act as a digital hit that sets the strobed memories the way a real hit does. The cell is modelled synchronously on a system clock. The analog front-end and the injection capacitor are outside this block.

Top module: `pixel_hit_cell`

## Requirements
- R1: After the power-up reset (`rst_n` low), all hit memories, the mask bit and the pulse-enable bit are 0. `hit_state_o` is 0, and both pulse outputs are 0 even while `pulse_i` is 1.
- R2: At a clock edge where `strobe_n[i]` is 0 and the effective hit is present (`fe_hit_n` = 0, or a routed digital pulse), memory i reads 1 from the next cycle on. It then stays 1 until a clear, whatever the front-end does afterwards.
- R3: A memory whose strobe line is 1 keeps its value, whatever `fe_hit_n` does.
- R4: `hit_state_o` is 1 when any memory whose `memsel_n` line is 0 holds 1 and the mask bit is 0. With several select lines low, the output is the OR of those memories.
- R5: A falling edge of `enc_clr_i` (1 in one cycle, 0 in the next) clears every memory selected in the cycle where it reads 0. The rising edge and a steady high level clear nothing.
- R6: `gclr_n` = 0 at a clock edge clears all three memories.
- R7: When a set and a clear reach the same memory in the same cycle, the memory ends up 0.
- R8: With the mask bit at 1, `hit_state_o` is 0. The memories keep their contents and show again once the mask bit returns to 0.
- R9: A configuration write takes `cfg_data_i` only when `cfg_col_i` and `cfg_row_i` are both 1. `cfg_tgt_i` = 0 writes the pulse-enable bit and `cfg_tgt_i` = 1 writes the mask bit. No other write changes either bit.
- R10: With pulse enable at 1, `pulse_kind_i` = 1 drives `apulse_o` = `pulse_i` and sets no memory. `pulse_kind_i` = 0 drives `dpulse_o` = `pulse_i`, and that pulse sets the strobed memories.
- R11: With pulse enable at 0, `pulse_i` drives neither pulse output and sets no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low |
| fe_hit_n | input | 1 | Discriminated front-end output, low = hit |
| strobe_n | input | 3 | Per-memory capture strobes, active low |
| memsel_n | input | 3 | Readout and clear select, active low |
| gclr_n | input | 1 | Global clear of all memories, active low |
| enc_clr_i | input | 1 | Encoder clear, acts on its falling edge |
| cfg_data_i | input | 1 | Configuration write data |
| cfg_col_i | input | 1 | Column select of the configuration write |
| cfg_row_i | input | 1 | Row select of the configuration write |
| cfg_tgt_i | input | 1 | Configuration target: 0 pulse enable, 1 mask |
| pulse_kind_i | input | 1 | Test pulse routing: 0 digital, 1 analog |
| pulse_i | input | 1 | Test pulse |
| hit_state_o | output | 1 | Selected hit state to the readout encoder |
| dpulse_o | output | 1 | Digital test pulse in effect |
| apulse_o | output | 1 | Analog injection request |

## Verification
The case most likely to go wrong is a capture and a clear landing on the same memory in the same cycle. This can happen because strobes and encoder clears are asynchronous to each other in use. The bench sets a memory, then puts the falling edge of the encoder clear in the same cycle as an open strobe and a front-end hit on that memory. A second case uses a global clear together with a set. Each case is judged by reading the memory back through the select and expecting 0. A companion case checks the reverse: a strobe with a quiet front-end must leave a set memory set.

// File: rtl/pixhit_pkg.sv
package pixhit_pkg;

  localparam int unsigned PH_MEMS = 3;

  typedef enum logic {
    CFG_PULSE_EN = 1'b0,
    CFG_MASK     = 1'b1
  } cfg_tgt_e;

  typedef enum logic {
    PK_DIGITAL = 1'b0,
    PK_ANALOG  = 1'b1
  } pulse_kind_e;

  // next value of one hit memory: a clear has priority over a set
  function automatic logic mem_next(input logic q, input logic set, input logic clr);
    return clr ? 1'b0 : (q | set);
  endfunction

  // falling edge seen between the registered and the current level
  function automatic logic fell(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

endpackage

// File: rtl/pixhit_cfg.sv
module pixhit_cfg
  import pixhit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic col_i,
  input  logic row_i,
  input  logic tgt_i,
  input  logic data_i,
  output logic mask_q,
  output logic pen_q
);

  logic addr_hit;
  logic wr_mask;
  logic wr_pen;

  assign addr_hit = col_i & row_i;
  assign wr_mask  = addr_hit & (cfg_tgt_e'(tgt_i) == CFG_MASK);
  assign wr_pen   = addr_hit & (cfg_tgt_e'(tgt_i) == CFG_PULSE_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      pen_q  <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= data_i;
      if (wr_pen)  pen_q  <= data_i;
    end
  end

  // R9: unaddressed cycles leave both bits alone
  a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(col_i && row_i) |=> ($stable(mask_q) && $stable(pen_q)));

  // R9: an addressed mask write lands the data and spares pulse enable
  a_r9_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (col_i && row_i && tgt_i) |=> (mask_q == $past(data_i)) && $stable(pen_q));

  // R9: an addressed pulse-enable write lands the data and spares the mask
  a_r9_pen_write: assert property (@(posedge clk) disable iff (!rst_n)
    (col_i && row_i && !tgt_i) |=> (pen_q == $past(data_i)) && $stable(mask_q));

endmodule

// File: rtl/pixhit_pulse.sv
module pixhit_pulse
  import pixhit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pen_i,
  input  logic kind_i,
  input  logic pulse_i,
  output logic dpulse_o,
  output logic apulse_o
);

  logic gated;

  assign gated    = pen_i & pulse_i;
  assign dpulse_o = gated & (pulse_kind_e'(kind_i) == PK_DIGITAL);
  assign apulse_o = gated & (pulse_kind_e'(kind_i) == PK_ANALOG);

  // R11: nothing leaves the cell while pulsing is disabled
  a_r11_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !pen_i |-> (!dpulse_o && !apulse_o));

  // R10: the two routes never fire together
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dpulse_o && apulse_o));

endmodule

// File: rtl/pixhit_bit.sv
module pixhit_bit
  import pixhit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= mem_next(q_o, set_i, clr_i);
  end

  // R7: a clear always lands, even against a simultaneous set
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !q_o);

  // R2: a set without clear lands
  a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> q_o);

  // R2: a stored hit is held until cleared
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);

endmodule

// File: rtl/pixhit_rdo.sv
module pixhit_rdo
  import pixhit_pkg::*;
#(
  parameter int unsigned NUM_MEM = PH_MEMS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enc_clr_i,
  input  logic [NUM_MEM-1:0] memsel_n,
  input  logic [NUM_MEM-1:0] state_i,
  input  logic               mask_i,
  output logic               enc_fall_o,
  output logic [NUM_MEM-1:0] sel_clr_o,
  output logic               hit_state_o
);

  logic               enc_q;
  logic [NUM_MEM-1:0] sel;
  logic               any_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enc_q <= 1'b0;
    else        enc_q <= enc_clr_i;
  end

  assign sel        = ~memsel_n;
  assign enc_fall_o = fell(enc_q, enc_clr_i);
  assign any_sel    = |(state_i & sel);
  assign hit_state_o = any_sel & ~mask_i;

  for (genvar i = 0; i < NUM_MEM; i++) begin : g_clr
    assign sel_clr_o[i] = enc_fall_o & sel[i];
  end

  // R8: a masked pixel shows nothing
  a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i |-> !hit_state_o);

  // R5: the rising edge of the encoder clear clears nothing
  a_r5_no_rise_clear: assert property (@(posedge clk) disable iff (!rst_n)
    enc_clr_i |-> (sel_clr_o == '0));

  // R5: clears only reach selected memories
  a_r5_sel_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_clr_o & memsel_n) == '0);

endmodule

// File: rtl/pixel_hit_cell.sv
module pixel_hit_cell
  import pixhit_pkg::*;
#(
  parameter int unsigned NUM_MEM = PH_MEMS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fe_hit_n,
  input  logic [NUM_MEM-1:0] strobe_n,
  input  logic [NUM_MEM-1:0] memsel_n,
  input  logic               gclr_n,
  input  logic               enc_clr_i,
  input  logic               cfg_data_i,
  input  logic               cfg_col_i,
  input  logic               cfg_row_i,
  input  logic               cfg_tgt_i,
  input  logic               pulse_kind_i,
  input  logic               pulse_i,
  output logic               hit_state_o,
  output logic               dpulse_o,
  output logic               apulse_o
);

  logic               mask_q;
  logic               pen_q;
  logic               hit_eff;
  logic               enc_fall;
  logic [NUM_MEM-1:0] sel_clr;
  logic [NUM_MEM-1:0] mem_set;
  logic [NUM_MEM-1:0] mem_clr;
  logic [NUM_MEM-1:0] state_q;

  pixhit_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .col_i  (cfg_col_i),
    .row_i  (cfg_row_i),
    .tgt_i  (cfg_tgt_i),
    .data_i (cfg_data_i),
    .mask_q (mask_q),
    .pen_q  (pen_q)
  );

  pixhit_pulse u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .pen_i    (pen_q),
    .kind_i   (pulse_kind_i),
    .pulse_i  (pulse_i),
    .dpulse_o (dpulse_o),
    .apulse_o (apulse_o)
  );

  // a digital test pulse behaves exactly like a front-end hit
  assign hit_eff = ~fe_hit_n | dpulse_o;

  for (genvar i = 0; i < NUM_MEM; i++) begin : g_mem
    assign mem_set[i] = ~strobe_n[i] & hit_eff;
    assign mem_clr[i] = ~gclr_n | sel_clr[i];

    pixhit_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (mem_set[i]),
      .clr_i (mem_clr[i]),
      .q_o   (state_q[i])
    );
  end

  pixhit_rdo #(.NUM_MEM(NUM_MEM)) u_rdo (
    .clk         (clk),
    .rst_n       (rst_n),
    .enc_clr_i   (enc_clr_i),
    .memsel_n    (memsel_n),
    .state_i     (state_q),
    .mask_i      (mask_q),
    .enc_fall_o  (enc_fall),
    .sel_clr_o   (sel_clr),
    .hit_state_o (hit_state_o)
  );

  // R6: a global clear empties every memory
  a_r6_global_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !gclr_n |=> (state_q == '0));

  // R3: with all strobes closed and no clear, memories do not move
  a_r3_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (&strobe_n && gclr_n && !enc_fall) |=> (state_q == $past(state_q)));

  // R11: without pulse enable, a pulse with a quiet front-end sets nothing
  a_r11_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!pen_q && fe_hit_n) |-> (mem_set == '0));

endmodule

// File: tb/pixel_hit_cell_tb.sv
`timescale 1ns/1ps
module pixel_hit_cell_tb;

  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         fe_hit_n;
  logic [N-1:0] strobe_n;
  logic [N-1:0] memsel_n;
  logic         gclr_n;
  logic         enc_clr_i;
  logic         cfg_data_i, cfg_col_i, cfg_row_i, cfg_tgt_i;
  logic         pulse_kind_i, pulse_i;
  logic         hit_state_o, dpulse_o, apulse_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pixel_hit_cell u_dut (
    .clk(clk), .rst_n(rst_n), .fe_hit_n(fe_hit_n), .strobe_n(strobe_n),
    .memsel_n(memsel_n), .gclr_n(gclr_n), .enc_clr_i(enc_clr_i),
    .cfg_data_i(cfg_data_i), .cfg_col_i(cfg_col_i), .cfg_row_i(cfg_row_i),
    .cfg_tgt_i(cfg_tgt_i), .pulse_kind_i(pulse_kind_i), .pulse_i(pulse_i),
    .hit_state_o(hit_state_o), .dpulse_o(dpulse_o), .apulse_o(apulse_o)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    fe_hit_n = 1'b1; strobe_n = '1; memsel_n = '1; gclr_n = 1'b1; enc_clr_i = 1'b0;
    cfg_data_i = 1'b0; cfg_col_i = 1'b0; cfg_row_i = 1'b0; cfg_tgt_i = 1'b0;
    pulse_kind_i = 1'b0; pulse_i = 1'b0;
  endtask

  // read one memory through the select; combinational, no edge involved
  task automatic read_mem(input int i, output logic v);
    memsel_n = ~(N'(1) << i);
    #1 v = hit_state_o;
    memsel_n = '1;
  endtask

  task automatic clear_all();
    gclr_n = 1'b0; tick(); gclr_n = 1'b1;
  endtask

  task automatic set_mems(input logic [N-1:0] m);
    fe_hit_n = 1'b0; strobe_n = ~m; tick(); fe_hit_n = 1'b1; strobe_n = '1;
  endtask

  task automatic cfg_write(input logic tgt, input logic d, input logic col, input logic row);
    cfg_tgt_i = tgt; cfg_data_i = d; cfg_col_i = col; cfg_row_i = row;
    tick();
    cfg_col_i = 1'b0; cfg_row_i = 1'b0; cfg_data_i = 1'b0;
  endtask

  task automatic t_reset();
    logic v;
    memsel_n = '0; #1 check("R1", "state after reset", hit_state_o, 1'b0);
    memsel_n = '1;
    pulse_i = 1'b1; pulse_kind_i = 1'b1;
    #1 check("R1", "apulse after reset", apulse_o, 1'b0);
    pulse_kind_i = 1'b0;
    #1 check("R1", "dpulse after reset", dpulse_o, 1'b0);
    pulse_i = 1'b0;
    for (int i = 0; i < N; i++) begin
      read_mem(i, v); check("R1", "memory clear after reset", v, 1'b0);
    end
  endtask

  task automatic t_capture();
    logic v;
    clear_all();
    set_mems(3'b001);
    read_mem(0, v); check("R2", "strobed memory 0 set", v, 1'b1);
    read_mem(1, v); check("R3", "unstrobed memory 1", v, 1'b0);
    read_mem(2, v); check("R3", "unstrobed memory 2", v, 1'b0);
    strobe_n = 3'b110; fe_hit_n = 1'b1; tick(); tick(); strobe_n = '1;
    read_mem(0, v); check("R2", "memory 0 held with quiet front-end", v, 1'b1);
    fe_hit_n = 1'b0; tick(); tick(); fe_hit_n = 1'b1;
    read_mem(2, v); check("R3", "hit with closed strobes", v, 1'b0);
  endtask

  task automatic t_select();
    clear_all();
    set_mems(3'b001);
    memsel_n = 3'b001; #1 check("R4", "select 1 and 2 only", hit_state_o, 1'b0);
    memsel_n = 3'b010; #1 check("R4", "select 0 and 2 OR", hit_state_o, 1'b1);
    memsel_n = '1;     #1 check("R4", "nothing selected", hit_state_o, 1'b0);
  endtask

  task automatic t_enc_clear();
    logic v;
    clear_all();
    set_mems(3'b101);
    memsel_n = 3'b110; enc_clr_i = 1'b1; tick();
    #1 check("R5", "rising edge keeps memory 0", hit_state_o, 1'b1);
    tick();
    #1 check("R5", "high level keeps memory 0", hit_state_o, 1'b1);
    enc_clr_i = 1'b0; tick(); memsel_n = '1;
    read_mem(0, v); check("R5", "falling edge clears memory 0", v, 1'b0);
    read_mem(2, v); check("R5", "unselected memory 2 kept", v, 1'b1);
  endtask

  task automatic t_gclr();
    logic v;
    set_mems(3'b111);
    clear_all();
    for (int i = 0; i < N; i++) begin
      read_mem(i, v); check("R6", "global clear", v, 1'b0);
    end
  endtask

  task automatic t_clear_wins();
    logic v;
    clear_all();
    set_mems(3'b001);
    memsel_n = 3'b110; enc_clr_i = 1'b1; tick();
    enc_clr_i = 1'b0; fe_hit_n = 1'b0; strobe_n = 3'b110; tick();
    fe_hit_n = 1'b1; strobe_n = '1; memsel_n = '1;
    read_mem(0, v); check("R7", "encoder clear beats set", v, 1'b0);
    gclr_n = 1'b0; fe_hit_n = 1'b0; strobe_n = 3'b101; tick();
    gclr_n = 1'b1; fe_hit_n = 1'b1; strobe_n = '1;
    read_mem(1, v); check("R7", "global clear beats set", v, 1'b0);
  endtask

  task automatic t_config();
    logic v;
    clear_all();
    set_mems(3'b010);
    cfg_write(1'b1, 1'b1, 1'b1, 1'b0);
    read_mem(1, v); check("R9", "mask write without row", v, 1'b1);
    cfg_write(1'b1, 1'b1, 1'b0, 1'b1);
    read_mem(1, v); check("R9", "mask write without column", v, 1'b1);
    cfg_write(1'b1, 1'b1, 1'b1, 1'b1);
    read_mem(1, v); check("R8", "masked pixel hidden", v, 1'b0);
    pulse_i = 1'b1; pulse_kind_i = 1'b0;
    #1 check("R9", "mask write leaves pulse enable 0", dpulse_o, 1'b0);
    pulse_i = 1'b0;
    cfg_write(1'b1, 1'b0, 1'b1, 1'b1);
    read_mem(1, v); check("R8", "unmask shows kept memory", v, 1'b1);
  endtask

  task automatic t_pulse();
    logic v;
    clear_all();
    pulse_i = 1'b1; pulse_kind_i = 1'b0; strobe_n = 3'b011; tick();
    pulse_i = 1'b0; strobe_n = '1;
    read_mem(2, v); check("R11", "disabled digital pulse sets nothing", v, 1'b0);
    cfg_write(1'b0, 1'b1, 1'b1, 1'b1);
    pulse_kind_i = 1'b1; pulse_i = 1'b1; strobe_n = 3'b011;
    #1 check("R10", "analog route apulse", apulse_o, 1'b1);
    check("R10", "analog route dpulse", dpulse_o, 1'b0);
    tick(); pulse_i = 1'b0; strobe_n = '1;
    read_mem(2, v); check("R10", "analog pulse sets no memory", v, 1'b0);
    pulse_kind_i = 1'b0; pulse_i = 1'b1; strobe_n = 3'b011;
    #1 check("R10", "digital route dpulse", dpulse_o, 1'b1);
    check("R10", "digital route apulse", apulse_o, 1'b0);
    tick(); pulse_i = 1'b0; strobe_n = '1;
    read_mem(2, v); check("R10", "digital pulse sets strobed memory", v, 1'b1);
    read_mem(0, v); check("R10", "digital pulse spares unstrobed memory", v, 1'b0);
    cfg_write(1'b0, 1'b0, 1'b1, 1'b1);
    pulse_i = 1'b1; pulse_kind_i = 1'b1;
    #1 check("R11", "pulse enable cleared, apulse", apulse_o, 1'b0);
    pulse_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_capture();
    t_select();
    t_enc_clear();
    t_gclr();
    t_clear_wins();
    t_config();
    t_pulse();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule